// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Driver Generator

This block produces the four gate drive lines of a phase-shifted full bridge. It has two identical legs, each built from an up-counting timebase, a compare-driven set/clear stage and a dead-band stage. Each dead-band stage emits an active-high complementary pair. The first leg is the master. The second leg is the follower. Its counter is realigned on every master zero so that it trails the master by a programmable number of counts. The follower's set/clear actions are the inverse of the master's. With both compares held at half the period, the phase shift alone then sets the effective bridge duty.

Period, compare, phase shift, rising dead time and falling dead time come in on input ports. The block holds them in working copies, and those copies are refreshed only at a master zero, so a value that changes mid-period never disturbs the period in progress. While the enable is low the working copies follow the inputs. When enable rises, the first period therefore starts with the values present on the ports.

Top module: `psfb_pwm`

## Requirements
- R1: While rst_ni is low or enable_i is low, all four gate outputs are 0 in that same cycle, and both counters are held at zero.
- R2: While enabled, the master counter steps 0, 1, …, P and then returns to 0, where P is the working period. The master pattern therefore repeats every P+1 cycles.
- R3: The master set/clear level is set on the edge that follows a cycle in which the master count is 0. It is cleared on the edge that follows a cycle in which the count equals the working compare. When both conditions hold in the same cycle, the set wins.
- R4: The follower set/clear level uses the opposite actions. It is cleared after a follower count of 0 and set after a follower count equal to the working compare. The clear wins when both hold together.
- R5: Every master zero reloads the follower counter. After each enabled edge, the follower count plus the working phase, taken modulo P+1, equals the master count. The follower count therefore reaches zero a number of cycles after the master equal to the phase, and a phase of 0 keeps both counters equal.
- R6: A phase input equal to or above period_i is taken as period_i − 1.
- R7: New period, compare, phase and dead-time inputs are taken into the working copies only on the edge that ends a master-zero cycle, or while disabled.
- R8: Each leg's A output follows its set/clear level one cycle late. Each rise of A is held back until the level has stayed high for more than the working rising delay in cycles, so a high pulse no longer than that delay never appears on A.
- R9: Each leg's B output is the inverse of the same delayed level. Each rise of B is held back until the level has stayed low for more than the working falling delay in cycles.
- R10: The A and B outputs of a leg are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable; low forces the outputs low and the counters to zero |
| period_i | input | CNT_W | Period value P; a period is P+1 counts (P ≥ 2) |
| compare_i | input | CNT_W | Compare value shared by both legs |
| phase_i | input | CNT_W | Follower lag in counts |
| rise_dly_i | input | CNT_W | Rising-edge dead time in cycles |
| fall_dly_i | input | CNT_W | Falling-edge dead time in cycles |
| gate_ma_o | output | 1 | Master leg, A side |
| gate_mb_o | output | 1 | Master leg, B side |
| gate_sa_o | output | 1 | Follower leg, A side |
| gate_sb_o | output | 1 | Follower leg, B side |

## Verification
Two collisions are provoked on purpose. In the first, a compare of 0 makes the compare match and the zero action land in the same master cycle, and the zero action must win on both legs. In the second, the phase and the period change while the follower is still counting, so the reload at the master zero is computed from the fresh inputs in the same cycle that the working copies take them. A behavioural model in the bench predicts all four outputs on every clock, and any disagreement is reported.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  typedef enum logic {LEG_MASTER = 1'b0, LEG_FOLLOW = 1'b1} leg_role_e;

  // follower reload value: count that sits ph steps behind a master count of 1
  function automatic logic [31:0] follow_load(input logic [31:0] per, input logic [31:0] ph);
    if (ph == 0)      return 32'd1;
    else if (ph == 1) return 32'd0;
    else              return per - ph + 32'd2;
  endfunction
endpackage

// File: rtl/psfb_timebase.sv
module psfb_timebase #(
  parameter int unsigned CNT_W  = 16,
  parameter bit          FOLLOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             do_load;

  assign cnt_inc = (cnt_q >= per_i) ? '0 : cnt_q + 1'b1;

  generate
    if (FOLLOW) begin : g_follow
      assign do_load = load_i;
    end else begin : g_master
      assign do_load = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!run_i)   cnt_q <= '0;
    else if (do_load)  cnt_q <= load_val_i;
    else               cnt_q <= cnt_inc;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/psfb_action.sv
module psfb_action
  import psfb_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter leg_role_e   ROLE  = LEG_MASTER
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             act_o
);
  localparam logic ZERO_LVL = (ROLE == LEG_MASTER);

  logic act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              act_q <= 1'b0;
    else if (!run_i)          act_q <= 1'b0;
    else if (cnt_i == '0)     act_q <= ZERO_LVL;
    else if (cnt_i == cmp_i)  act_q <= ~ZERO_LVL;
  end

  assign act_o = act_q;
endmodule

// File: rtl/psfb_deadband.sv
module psfb_deadband #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             act_i,
  input  logic [CNT_W-1:0] red_i,
  input  logic [CNT_W-1:0] fed_i,
  output logic             a_o,
  output logic             b_o
);
  logic             lvl_q;
  logic [CNT_W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      held_q <= '0;
    end else if (!run_i) begin
      lvl_q  <= 1'b0;
      held_q <= '0;
    end else begin
      lvl_q <= act_i;
      if (act_i != lvl_q)  held_q <= '0;
      else if (held_q != '1) held_q <= held_q + 1'b1;
    end
  end

  assign a_o = run_i &  lvl_q & (held_q >= red_i);
  assign b_o = run_i & ~lvl_q & (held_q >= fed_i);
endmodule

// File: rtl/psfb_pwm.sv
module psfb_pwm
  import psfb_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DEF_PER   = 15000,
  parameter int unsigned DEF_CMP   = 7500,
  parameter int unsigned DEF_PHASE = 600,
  parameter int unsigned DEF_DEAD  = 300
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] compare_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] rise_dly_i,
  input  logic [CNT_W-1:0] fall_dly_i,
  output logic             gate_ma_o,
  output logic             gate_mb_o,
  output logic             gate_sa_o,
  output logic             gate_sb_o
);
  localparam int unsigned NLEG = 2;

  logic [CNT_W-1:0] per_q, cmp_q, ph_q, red_q, fed_q;
  logic [CNT_W-1:0] ph_clamp, sync_val;
  logic [31:0]      load_w;
  logic             mst_zero, take_new;
  logic [CNT_W-1:0] leg_cnt [NLEG];
  logic             leg_act [NLEG];
  logic             leg_a   [NLEG];
  logic             leg_b   [NLEG];

  assign ph_clamp = (phase_i >= period_i) ? period_i - 1'b1 : phase_i;
  assign load_w   = follow_load(32'(period_i), 32'(ph_clamp));
  assign sync_val = load_w[CNT_W-1:0];
  assign mst_zero = enable_i && (leg_cnt[0] == '0);
  assign take_new = !enable_i || mst_zero;

  // working copies, refreshed at master zero or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= CNT_W'(DEF_PER);
      cmp_q <= CNT_W'(DEF_CMP);
      ph_q  <= CNT_W'(DEF_PHASE);
      red_q <= CNT_W'(DEF_DEAD);
      fed_q <= CNT_W'(DEF_DEAD);
    end else if (take_new) begin
      per_q <= period_i;
      cmp_q <= compare_i;
      ph_q  <= ph_clamp;
      red_q <= rise_dly_i;
      fed_q <= fall_dly_i;
    end
  end

  generate
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
      localparam leg_role_e ROLE = (g == 0) ? LEG_MASTER : LEG_FOLLOW;

      psfb_timebase #(.CNT_W(CNT_W), .FOLLOW(g != 0)) u_tb (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (enable_i),
        .per_i      (per_q),
        .load_i     (mst_zero),
        .load_val_i (sync_val),
        .cnt_o      (leg_cnt[g])
      );

      psfb_action #(.CNT_W(CNT_W), .ROLE(ROLE)) u_act (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (enable_i),
        .cnt_i  (leg_cnt[g]),
        .cmp_i  (cmp_q),
        .act_o  (leg_act[g])
      );

      psfb_deadband #(.CNT_W(CNT_W)) u_db (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (enable_i),
        .act_i  (leg_act[g]),
        .red_i  (red_q),
        .fed_i  (fed_q),
        .a_o    (leg_a[g]),
        .b_o    (leg_b[g])
      );
    end
  endgenerate

  assign gate_ma_o = leg_a[0];
  assign gate_mb_o = leg_b[0];
  assign gate_sa_o = leg_a[1];
  assign gate_sb_o = leg_b[1];
endmodule

// File: rtl/psfb_pwm_chk.sv
module psfb_pwm_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic [CNT_W-1:0] per_q,
  input logic [CNT_W-1:0] ph_q,
  input logic [CNT_W-1:0] mst_cnt,
  input logic [CNT_W-1:0] slv_cnt,
  input logic             mst_act,
  input logic             slv_act,
  input logic             gate_ma_o,
  input logic             gate_mb_o,
  input logic             gate_sa_o,
  input logic             gate_sb_o
);
  logic [CNT_W:0] rel_sum, rel_exp;
  assign rel_sum = {1'b0, slv_cnt} + {1'b0, ph_q};
  assign rel_exp = (rel_sum > {1'b0, per_q}) ? rel_sum - {1'b0, per_q} - 1'b1 : rel_sum;

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !(gate_ma_o || gate_mb_o || gate_sa_o || gate_sb_o)); // R1
  AST_MST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && mst_cnt >= per_q) |=> (mst_cnt == '0)); // R2
  AST_MST_ZERO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && mst_cnt == '0) |=> mst_act); // R3
  AST_SLV_ZERO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && slv_cnt == '0) |=> !slv_act); // R4
  AST_PHASE_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(enable_i) && enable_i) |-> (rel_exp == {1'b0, mst_cnt})); // R5
  AST_PHASE_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |-> (ph_q < per_q)); // R6
  AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_ma_o && gate_mb_o) && !(gate_sa_o && gate_sb_o)); // R10
endmodule

bind psfb_pwm psfb_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .per_q     (per_q),
  .ph_q      (ph_q),
  .mst_cnt   (leg_cnt[0]),
  .slv_cnt   (leg_cnt[1]),
  .mst_act   (leg_act[0]),
  .slv_act   (leg_act[1]),
  .gate_ma_o (gate_ma_o),
  .gate_mb_o (gate_mb_o),
  .gate_sa_o (gate_sa_o),
  .gate_sb_o (gate_sb_o)
);

// File: tb/psfb_pwm_bench.sv
module psfb_pwm_bench;
  localparam int CW   = 16;
  localparam int SMAX = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [CW-1:0] per_in = 16'd39, cmp_in = 16'd20, ph_in = 16'd6, red_in = 16'd3, fed_in = 16'd2;
  logic ma, mb, sa, sb;

  int checks = 0, errors = 0;
  bit done = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  psfb_pwm #(.CNT_W(CW)) u_psfb_pwm (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
    .period_i(per_in), .compare_i(cmp_in), .phase_i(ph_in),
    .rise_dly_i(red_in), .fall_dly_i(fed_in),
    .gate_ma_o(ma), .gate_mb_o(mb), .gate_sa_o(sa), .gate_sb_o(sb)
  );

  // behavioural reference state
  int w_per, w_cmp, w_ph, w_red, w_fed;
  int mc, sc, mact, sact, mlv, mrun, slv, srun;

  function automatic int clamp_ph(int p, int ph);
    return (ph >= p) ? p - 1 : ph;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || !en) begin
      mc = 0; sc = 0; mact = 0; sact = 0; mlv = 0; mrun = 0; slv = 0; srun = 0;
      if (rst_n) begin
        w_per = per_in; w_cmp = cmp_in; w_ph = clamp_ph(per_in, ph_in);
        w_red = red_in; w_fed = fed_in;
      end
    end else begin
      int nmact, nsact, nmc, nsc, nph;
      if (mact != mlv) mrun = 0; else if (mrun < SMAX) mrun++;
      mlv = mact;
      if (sact != slv) srun = 0; else if (srun < SMAX) srun++;
      slv = sact;
      nmact = (mc == 0) ? 1 : (mc == w_cmp) ? 0 : mact;
      nsact = (sc == 0) ? 0 : (sc == w_cmp) ? 1 : sact;
      nmc = (mc >= w_per) ? 0 : mc + 1;
      if (mc == 0) begin
        nph = clamp_ph(per_in, ph_in);
        nsc = (1 - nph + per_in + 1) % (per_in + 1); // trails master-at-1 by nph
        w_per = per_in; w_cmp = cmp_in; w_ph = nph; w_red = red_in; w_fed = fed_in;
      end else begin
        nsc = (sc >= w_per) ? 0 : sc + 1;
      end
      mact = nmact; sact = nsact; mc = nmc; sc = nsc;
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  // compare every cycle, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit ema, emb, esa, esb;
      ema = en && mlv == 1 && mrun >= w_red;
      emb = en && mlv == 0 && mrun >= w_fed;
      esa = en && slv == 1 && srun >= w_red;
      esb = en && slv == 0 && srun >= w_fed;
      chk(ma, ema, "R1 R2 R3 R7 R8 master A");
      chk(mb, emb, "R1 R3 R7 R9 master B");
      chk(sa, esa, "R4 R5 R6 R7 R8 follower A");
      chk(sb, esb, "R4 R5 R6 R7 R9 follower B");
      chk(!((ma && mb) || (sa && sb)), 1'b1, "R10 pair overlap");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R2: spacing of master A rises equals P+1
  task automatic measure_period(input int exp);
    int t0, t1;
    @(posedge ma); t0 = cyc;
    @(posedge ma); t1 = cyc;
    checks++;
    if (t1 - t0 != exp) begin
      errors++;
      $display("FAIL R2 period actual=%0d expected=%0d", t1 - t0, exp);
    end
  endtask

  initial begin
    step(3);
    chk(ma | mb | sa | sb, 1'b0, "R1 reset outputs");
    rst_n = 1'b1;
    step(3);
    chk(ma | mb | sa | sb, 1'b0, "R1 disabled outputs");
    en = 1'b1;                                  // base pattern
    step(200);
    measure_period(40);
    @(negedge clk);
    cmp_in = 16'd10; ph_in = 16'd0;             // R7 mid-period change, R5 in phase
    step(17);
    per_in = 16'd25;                            // R7 period change mid-period
    step(200);
    measure_period(26);
    @(negedge clk);
    ph_in = 16'd90;                             // R6 clamp to period-1
    step(150);
    ph_in = 16'd25;                             // R6 equal to period
    step(120);
    cmp_in = 16'd0; ph_in = 16'd7;              // R3 R4 zero and compare collide
    step(150);
    en = 1'b0;                                  // R1 mid-run disable
    step(5);
    chk(ma | mb | sa | sb, 1'b0, "R1 disable mid-run");
    cmp_in = 16'd15; ph_in = 16'd1; red_in = 16'd0; fed_in = 16'd0; per_in = 16'd31;
    en = 1'b1;                                  // zero dead time, phase 1
    step(200);
    red_in = 16'd20; fed_in = 16'd12; ph_in = 16'd9; // R8 swallowed pulses
    step(250);
    red_in = 16'd2; fed_in = 16'd5; per_in = 16'd2; cmp_in = 16'd1; ph_in = 16'd1;
    step(100);                                  // smallest period
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule